// File: doc/BRIEF.md
# Nibble-Serial Converter Sample Link

This block moves one converter sample per word period between a signal processor and a DAC/ADC pair. A word is 16 bits wide and crosses the link as four 4-bit nibbles on four parallel data lines, least significant nibble first. The block derives its own nibble timing and a word-rate strobe from a single master clock. In full-rate mode a nibble lasts one master cycle. In half-rate mode every nibble, and so every word, lasts twice as long.

On the transmit side the block assembles four incoming nibbles into a signed 16-bit word. It clamps the word to what a 12-bit DAC code can represent, then drops the three least significant bits to form the code. The code changes once per word, and a one-cycle update flag marks the change. On the receive side a 13-bit signed ADC code is sampled once per word. It is widened to 16 bits with sign extension and two zero bits at the bottom, and sent out nibble by nibble during the following word. Outputs change on the rising master edge. Transmit nibbles are sampled on a falling edge.

Top module: `nibble_link`

## Requirements
- R1: While reset is low: `word_strb` is 1, `dac_upd` is 0, `dac_code` is 0x000 and `rx_nib` is 0x0. The first word after reset sends an all-zero RX word.
- R2: In full-rate mode (`half_rate`=0), `nib_tick` is 1 in every cycle. A new nibble starts every master cycle, and `word_strb` is high for exactly one cycle out of every four.
- R3: In half-rate mode (`half_rate`=1), each nibble lasts two master cycles and `rx_nib` holds its value across both. `nib_tick` is 0 in the first cycle and 1 in the second. `word_strb` is high for exactly two cycles out of every eight.
- R4: Nibble N0 is sent while `word_strb` is high, then N1, N2, N3 in turn. During nibble Nk, data line i carries bit 4k+i of the word.
- R5: The RX word is {adc_code[12], adc_code[12:0], 2'b00}.
- R6: `adc_code` is sampled only at the rising edge that ends nibble N3. That word is sent during the next word, and changes to `adc_code` at any other time do not affect it.
- R7: A TX nibble is sampled on the falling master edge of the cycle where `nib_tick` is 1. N0 supplies bits 3:0 and N3 supplies bits 15:12. In half-rate mode, values present only in the first cycle of a nibble are ignored.
- R8: If bits 15 and 14 of the TX word are equal, `dac_code` is bits 14:3 of the word, and bits 2:0 have no effect.
- R9: If bits 15 and 14 of the TX word differ, `dac_code` is 0x7FF when bit 15 is 0 and 0x800 when bit 15 is 1.
- R10: `dac_code` changes only in the cycle after the edge that ends nibble N3. In that cycle `dac_upd` is 1 for one cycle, and it is always the first cycle of `word_strb`. `dac_code` holds its value at all other times.
- R11: A TX word produces an update only once all four of its nibbles have been captured. A word cut short by reset never reaches `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_rate | input | 1 | 1 selects half-rate mode; change only at a word start |
| tx_nib | input | 4 | Transmit nibble lines from the processor |
| adc_code | input | 13 | Signed ADC sample |
| nib_tick | output | 1 | High in the last master cycle of each nibble period |
| word_strb | output | 1 | High during nibble N0 of each word |
| rx_nib | output | 4 | Receive nibble lines to the processor |
| dac_code | output | 12 | Signed DAC code |
| dac_upd | output | 1 | One-cycle flag when `dac_code` takes a new value |

## Verification
The bench drives the saturation boundaries 0x3FFF, 0x4000, 0xC000 and 0xBFFF, plus the extremes 0x7FFF and 0x8000. A design that tested magnitude against the wrong limit, or picked the clamp value from the wrong bit, returns a code off by one step or with the wrong sign. In half-rate mode the bench puts the complement of each nibble on the lines during the first cycle of that nibble. It also holds a corrupt ADC value during N1 of a word. A design that samples on the wrong cycle or edge, or that reads the ADC code straight into the outgoing nibbles, sends wrong words. A reset in the middle of a word, followed by a full word, exposes designs that keep stale nibbles or update from an incomplete word. The scoreboard compares nibble order and strobe widths in both modes, so a swapped nibble order or a wrong strobe width also shows up.

// File: rtl/nl_pkg.sv
`timescale 1ns/1ps
package nl_pkg;
   // Nibble-rate selection seen by the timing generator
   typedef enum logic {
      RATE_FULL = 1'b0,
      RATE_HALF = 1'b1
   } rate_e;
endpackage

// File: rtl/nl_timing.sv
`timescale 1ns/1ps
module nl_timing
   import nl_pkg::*;
#(
   parameter int NIBS    = 4,
   parameter bit HALF_EN = 1'b1,
   localparam int PH_W   = (NIBS > 1) ? $clog2(NIBS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            half_rate,
   output logic            tick,
   output logic [PH_W-1:0] ph,
   output logic            word_end,
   output logic            word_strb
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIBS - 1);

   rate_e           rate;
   logic            tick_w;
   logic [PH_W-1:0] ph_q;

   generate
      if (HALF_EN) begin : g_half
         logic div_q;
         assign rate = half_rate ? RATE_HALF : RATE_FULL;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 div_q <= 1'b0;
            else if (rate == RATE_HALF) div_q <= ~div_q;
            else                        div_q <= 1'b0;
         end
         assign tick_w = (rate == RATE_FULL) | div_q;
      end else begin : g_full
         assign rate   = RATE_FULL;
         assign tick_w = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ph_q <= '0;
      else if (tick_w) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
   end

   assign tick      = tick_w;
   assign ph        = ph_q;
   assign word_end  = tick_w && (ph_q == PH_LAST);
   assign word_strb = (ph_q == '0);

   AST_HALF_STRB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (HALF_EN && half_rate && $past(half_rate) && $rose(word_strb)) |=> word_strb)
      else $error("strobe shorter than two cycles in half-rate mode"); // R3
endmodule

// File: rtl/nl_tx_pack.sv
`timescale 1ns/1ps
module nl_tx_pack #(
   parameter int NIB_W   = 4,
   parameter int NIBS    = 4,
   parameter int DAC_W   = 12,
   parameter int DROP    = 3,
   localparam int PH_W   = (NIBS > 1) ? $clog2(NIBS) : 1,
   localparam int WORD_W = NIB_W * NIBS,
   localparam int GUARD  = WORD_W - DAC_W - DROP + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [PH_W-1:0]  ph,
   input  logic             word_end,
   input  logic [NIB_W-1:0] tx_nib,
   output logic [DAC_W-1:0] dac_code,
   output logic             dac_upd
);
   localparam logic [DAC_W-1:0] CODE_MAX = {1'b0, {(DAC_W-1){1'b1}}};
   localparam logic [DAC_W-1:0] CODE_MIN = ~CODE_MAX;

   logic [WORD_W-1:DROP] asm_w;   // dropped bits are never stored
   logic [NIBS-1:0]      seen_q;
   logic [GUARD-1:0]     guard_w;
   logic                 in_range;
   logic [DAC_W-1:0]     sat_code;
   logic [DAC_W-1:0]     code_q;
   logic                 upd_q;

   // Each kept word bit is its own falling-edge flop, loaded in its nibble slot
   generate
      for (genvar b = DROP; b < WORD_W; b++) begin : g_bit
         logic bit_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)                                bit_q <= 1'b0;
            else if (tick && (ph == PH_W'(b / NIB_W))) bit_q <= tx_nib[b % NIB_W];
         end
         assign asm_w[b] = bit_q;
      end
   endgenerate

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)          seen_q <= '0;
      else if (tick) begin
         if (ph == '0)     seen_q <= NIBS'(1);
         else              seen_q <= seen_q | (NIBS'(1) << ph);
      end
   end

   assign guard_w  = asm_w[WORD_W-1 -: GUARD];
   assign in_range = (guard_w == '0) || (guard_w == '1);
   assign sat_code = in_range ? asm_w[DROP +: DAC_W]
                              : (asm_w[WORD_W-1] ? CODE_MIN : CODE_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= word_end && (&seen_q);
         if (word_end && (&seen_q)) code_q <= sat_code;
      end
   end

   assign dac_code = code_q;
   assign dac_upd  = upd_q;

   AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      word_end |-> (&seen_q))
      else $error("word closed with a nibble missing"); // R11
   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      dac_upd |-> (dac_code[DAC_W-1] == $past(asm_w[WORD_W-1])))
      else $error("DAC code sign differs from word sign"); // R9
endmodule

// File: rtl/nl_rx_unpack.sv
`timescale 1ns/1ps
module nl_rx_unpack #(
   parameter int NIB_W   = 4,
   parameter int NIBS    = 4,
   parameter int ADC_W   = 13,
   localparam int PH_W   = (NIBS > 1) ? $clog2(NIBS) : 1,
   localparam int WORD_W = NIB_W * NIBS,
   localparam int PAD    = WORD_W - 1 - ADC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_end,
   input  logic [PH_W-1:0]  ph,
   input  logic [ADC_W-1:0] adc_code,
   output logic [NIB_W-1:0] rx_nib
);
   logic [WORD_W-1:0]           next_w;
   logic [WORD_W-1:0]           rx_q;
   logic [NIBS-1:0][NIB_W-1:0]  slice_w;

   generate
      if (PAD > 0) begin : g_pad
         assign next_w = {adc_code[ADC_W-1], adc_code, {PAD{1'b0}}};
      end else begin : g_nopad
         assign next_w = {adc_code[ADC_W-1], adc_code};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rx_q <= '0;
      else if (word_end) rx_q <= next_w;
   end

   assign slice_w = rx_q;
   assign rx_nib  = slice_w[ph];

   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_end |=> $stable(rx_q))
      else $error("outgoing RX word changed mid-word"); // R6
endmodule

// File: rtl/nibble_link.sv
`timescale 1ns/1ps
module nibble_link #(
   parameter int NIB_W    = 4,
   parameter int NIBS     = 4,
   parameter int ADC_W    = 13,
   parameter int DAC_W    = 12,
   parameter int DAC_DROP = 3,
   parameter bit HALF_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             half_rate,
   input  logic [NIB_W-1:0] tx_nib,
   input  logic [ADC_W-1:0] adc_code,
   output logic             nib_tick,
   output logic             word_strb,
   output logic [NIB_W-1:0] rx_nib,
   output logic [DAC_W-1:0] dac_code,
   output logic             dac_upd
);
   localparam int WORD_W = NIB_W * NIBS;
   localparam int PH_W   = (NIBS > 1) ? $clog2(NIBS) : 1;

   generate
      if (NIB_W < 1 || NIBS < 2) begin : g_bad_shape
         $error("nibble_link: need NIB_W >= 1 and NIBS >= 2");
      end
      if (DAC_W < 2 || DAC_W + DAC_DROP > WORD_W - 1) begin : g_bad_dac
         $error("nibble_link: DAC field does not fit below the sign bit");
      end
      if (ADC_W < 2 || ADC_W > WORD_W - 1) begin : g_bad_adc
         $error("nibble_link: ADC code does not fit below the sign bit");
      end
   endgenerate

   logic            tick_w;
   logic            end_w;
   logic [PH_W-1:0] ph_w;

   nl_timing #(.NIBS(NIBS), .HALF_EN(HALF_EN)) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_rate (half_rate),
      .tick      (tick_w),
      .ph        (ph_w),
      .word_end  (end_w),
      .word_strb (word_strb)
   );

   nl_tx_pack #(.NIB_W(NIB_W), .NIBS(NIBS), .DAC_W(DAC_W), .DROP(DAC_DROP)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_w),
      .ph       (ph_w),
      .word_end (end_w),
      .tx_nib   (tx_nib),
      .dac_code (dac_code),
      .dac_upd  (dac_upd)
   );

   nl_rx_unpack #(.NIB_W(NIB_W), .NIBS(NIBS), .ADC_W(ADC_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_end (end_w),
      .ph       (ph_w),
      .adc_code (adc_code),
      .rx_nib   (rx_nib)
   );

   assign nib_tick = tick_w;

   AST_UPD_IN_STRB: assert property (@(posedge clk) disable iff (!rst_n)
      dac_upd |-> word_strb)
      else $error("DAC update outside word strobe"); // R10
   AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_upd |-> $stable(dac_code))
      else $error("DAC code moved without update flag"); // R10
endmodule

// File: tb/nibble_link_bench.sv
`timescale 1ns/1ps
module nibble_link_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        half_rate;
   logic [3:0]  tx_nib;
   logic [12:0] adc_code;
   logic        nib_tick;
   logic        word_strb;
   logic [3:0]  rx_nib;
   logic [11:0] dac_code;
   logic        dac_upd;

   always #2 clk = ~clk;   // 250 MHz

   nibble_link u_nibble_link (
      .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .tx_nib(tx_nib),
      .adc_code(adc_code), .nib_tick(nib_tick), .word_strb(word_strb),
      .rx_nib(rx_nib), .dac_code(dac_code), .dac_upd(dac_upd)
   );

   int          n_cmp = 0;
   int          n_bad = 0;
   int          step  = 1;
   bit          done  = 1'b0;
   logic [11:0] tx_exp[$];
   logic [15:0] rx_exp[$];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] model_dac(input logic [15:0] w);
      int v;
      v = $signed(w);
      if (v > 16383)  return 12'h7FF;
      if (v < -16384) return 12'h800;
      return w[14:3];
   endfunction

   function automatic logic [15:0] model_rx(input logic [12:0] a);
      return {a[12], a, 2'b00};
   endfunction

   // Driver: called at posedge+1 of the first cycle of a word
   task automatic send_word(input logic [15:0] w, input logic [12:0] a, input bit half, input bit glitch);
      half_rate = half;
      step      = half ? 2 : 1;
      tx_exp.push_back(model_dac(w));
      rx_exp.push_back(model_rx(a));
      for (int k = 0; k < 4; k++) begin
         for (int s = 0; s < step; s++) begin
            tx_nib   = (half && s == 0) ? ~w[4*k +: 4] : w[4*k +: 4];
            adc_code = (glitch && k == 1) ? ~a : a;
            @(posedge clk); #1;
         end
      end
   endtask

   task automatic cut_by_reset(input logic [15:0] w);
      half_rate = 1'b0;
      step      = 1;
      for (int k = 0; k < 2; k++) begin
         tx_nib = w[4*k +: 4];
         @(posedge clk); #1;
      end
      rst_n = 1'b0;
      tx_exp.delete();
      rx_exp.delete();
      rx_exp.push_back(16'h0000);
      @(posedge clk); #2;
      check(dac_code == 12'h000, "R1 R11 code after mid-word reset", dac_code, 0);
      check(dac_upd == 1'b0, "R1 upd after mid-word reset", dac_upd, 0);
      check(word_strb == 1'b1, "R1 strobe after mid-word reset", word_strb, 1);
      @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   // Monitor: scoreboard compare as results appear
   initial begin
      bit          prev;
      bit          coll;
      int          idx;
      int          sub;
      int          slen;
      logic [15:0] got;
      logic [3:0]  held;
      logic [11:0] last_code;
      logic [15:0] ew;
      logic [11:0] ec;
      prev = 0; coll = 0; idx = 0; sub = 0; slen = 0; got = '0; held = '0; last_code = '0;
      forever begin
         @(posedge clk); #3;
         if (!rst_n) begin
            prev = 0; coll = 0; slen = 0; last_code = '0;
            continue;
         end
         if (word_strb && !prev) begin
            coll = 1; idx = 0; sub = 0; got = '0; slen = 0;
         end
         if (word_strb) slen++;
         else if (prev) check(slen == step, "R2 R3 strobe width", slen, step);
         if (coll) begin
            check(nib_tick == (sub == step - 1), "R2 R3 nibble tick", nib_tick, (sub == step - 1));
            if (sub == 0) begin
               got[4*idx +: 4] = rx_nib;
               held = rx_nib;
            end else begin
               check(rx_nib == held, "R3 nibble held", rx_nib, held);
            end
            sub++;
            if (sub == step) begin
               sub = 0;
               idx++;
            end
            if (idx == 4) begin
               coll = 0;
               if (rx_exp.size() > 0) begin
                  ew = rx_exp.pop_front();
                  check(got == ew, "R4 R5 R6 rx word", got, ew);
               end
            end
         end
         if (dac_upd) begin
            check(word_strb == 1'b1, "R10 update inside strobe", word_strb, 1);
            if (tx_exp.size() > 0) begin
               ec = tx_exp.pop_front();
               check(dac_code == ec, "R7 R8 R9 dac code", dac_code, ec);
            end
            last_code = dac_code;
         end else begin
            check(dac_code == last_code, "R10 code held", dac_code, last_code);
         end
         prev = word_strb;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; half_rate = 1'b0; tx_nib = '0; adc_code = '0;
      rx_exp.push_back(16'h0000);   // first word after reset
      repeat (3) @(posedge clk);
      #3;
      check(word_strb == 1'b1, "R1 reset strobe", word_strb, 1);
      check(dac_upd == 1'b0, "R1 reset upd", dac_upd, 0);
      check(dac_code == 12'h000, "R1 reset code", dac_code, 0);
      check(rx_nib == 4'h0, "R1 reset rx", rx_nib, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // Full-rate: in-range, boundaries, dropped low bits (R8 R9)
      send_word(16'h1238, 13'h0A5A, 0, 0);
      send_word(16'h3FFF, 13'h1FFF, 0, 0);
      send_word(16'h4000, 13'h1000, 0, 1);
      send_word(16'hC000, 13'h0FFF, 0, 0);
      send_word(16'hBFFF, 13'h0001, 0, 1);
      send_word(16'h7FFF, 13'h1555, 0, 0);
      send_word(16'h8000, 13'h0AAA, 0, 0);
      send_word(16'h0007, 13'h1ABC, 0, 0);
      send_word(16'hFFF8, 13'h0000, 0, 0);

      // Half-rate with first-cycle garbage on TX lines (R3 R7)
      send_word(16'hA5C3, 13'h1234, 1, 0);
      send_word(16'h2B6F, 13'h0F0F, 1, 1);
      send_word(16'h5000, 13'h1F00, 1, 0);
      send_word(16'hE001, 13'h00F0, 1, 0);

      // Back to full rate
      send_word(16'h0F18, 13'h0321, 0, 1);
      send_word(16'hF0E8, 13'h1C0D, 0, 0);

      // Reset in the middle of a word (R11)
      cut_by_reset(16'h6666);
      send_word(16'h0128, 13'h0777, 0, 0);
      send_word(16'hFED8, 13'h1888, 1, 1);
      send_word(16'h2468, 13'h0246, 0, 0);
      send_word(16'h1000, 13'h0135, 0, 0);

      repeat (10) @(posedge clk);
      #2;
      check(tx_exp.size() == 0, "R10 every word updated", tx_exp.size(), 0);
      check(rx_exp.size() == 0, "R4 every rx word sent", rx_exp.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule